// File: doc/BRIEF.md
# Two-Stage Overlapped Interrupt Sequencer

This block steps a small accumulator machine through its instructions with two stages that overlap by one clock. The bus stage issues one memory read, or one idle cycle, each clock and latches any byte it reads into a memory data register. The work stage acts on that register one clock later: it writes accumulator bytes, changes the interrupt-disable flag or captures interrupt vector bytes. Every clock therefore carries bus cycle N and work cycle N-1 together. The first work cycle of each instruction, the one that pairs with the opcode fetch, is idle.

Four instructions are decoded. Opcode 0xA9 is an immediate accumulator load that takes one or two operand bytes, chosen by a width input. 0x58 clears interrupt-disable. 0x78 sets it. Every other opcode is a two-cycle implied no-operation. The level interrupt input is tested in the final bus cycle of each instruction against the flag held at that moment. When the test passes, the next bus cycle reads the vector address instead of an opcode. A flag change made by the final work cycle of an instruction therefore counts only from the next instruction onward. If an implied instruction is followed by an interrupt, its idle second cycle becomes a real read of the current program counter.

Top module: `ovl_irq_seq`

## Requirements
- R1: During and right after reset the accumulator is 0, the interrupt-disable flag (`int_dis`) is 1, `vec_valid` is 0, and the first bus cycle reads the opcode at `reset_addr`.
- R2: With `acc_8bit`=1, opcode 0xA9 takes one operand byte. The byte replaces the accumulator low half, the high half is kept, and the next opcode is read from the address after the operand.
- R3: With `acc_8bit`=0, opcode 0xA9 takes two operand bytes, low first. The accumulator becomes {second byte, first byte}.
- R4: An operand byte read in bus cycle N is written by the work stage at the edge that ends cycle N+1, so `acc` shows it from cycle N+2 onward.
- R5: Any opcode other than 0xA9 takes two bus cycles. When no interrupt follows, the second cycle is idle (`mem_rd`=0).
- R6: The interrupt is tested in the final bus cycle of each instruction. If `irq`=1 and `int_dis`=0 in that cycle, the next bus cycle reads `VEC_ADDR` instead of an opcode.
- R7: When an interrupt is taken after an implied opcode, that opcode's second cycle becomes a read at the address following the opcode, and the program counter is not advanced.
- R8: Opcode 0x58 clears `int_dis` in its final work cycle, after the test. An interrupt pending at that point is taken only after the next instruction ends.
- R9: Opcode 0x78 sets `int_dis` in its final work cycle, after its own test. It cannot block an interrupt tested in its own final bus cycle.
- R10: A taken interrupt reads `VEC_ADDR` and then `VEC_ADDR`+1 and sets `int_dis`. In the next cycle `vec_valid` is 1 for exactly one cycle with `vector` = {second byte, first byte}, and that same cycle reads the opcode at `vector`.
- R11: While `int_dis`=1, `irq` has no effect: opcode fetches continue in sequence and implied second cycles stay idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reset_addr | input | AW | Address of the first opcode after reset |
| acc_8bit | input | 1 | 1: immediate load uses one byte; 0: two bytes |
| irq | input | 1 | Level interrupt request |
| mem_rdata | input | DW | Read data, valid in the cycle its address is driven |
| mem_addr | output | AW | Bus read address |
| mem_rd | output | 1 | Bus read strobe; 0 marks an idle bus cycle |
| acc | output | 2*DW | Accumulator |
| int_dis | output | 1 | Interrupt-disable flag |
| vec_valid | output | 1 | One-cycle strobe when a vector is complete |
| vector | output | AW | Interrupt vector assembled from two reads |

## Verification
Two things meet in the same clock at every instruction boundary: the interrupt test made by the bus stage and the flag write made by the work stage for the previous cycle. The bench holds `irq` high and runs a flag-clearing opcode followed by an implied opcode, then by a flag-setting opcode, then by a two-byte load. It then judges, by cycle count from reset, whether the read that follows is the next opcode or `VEC_ADDR`, and checks the read address and strobe of the converted idle cycle. The load cases also confirm that the final accumulator write completes in the same clock as the first vector read.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
   typedef enum logic [2:0] {
      BS_FETCH,
      BS_OPND_LO,
      BS_OPND_HI,
      BS_IMPLIED,
      BS_VEC_HI
   } bus_state_t;

   typedef enum logic [2:0] {
      WK_IDLE,
      WK_ACC_LO,
      WK_ACC_HI,
      WK_FLAG_CLR,
      WK_FLAG_SET,
      WK_VEC_LO,
      WK_VEC_HI
   } work_op_t;

   localparam logic [7:0] OPC_LOAD_IMM = 8'hA9;
   localparam logic [7:0] OPC_DIS_CLR  = 8'h58;
   localparam logic [7:0] OPC_DIS_SET  = 8'h78;
endpackage

// File: rtl/ovl_bus_stage.sv
module ovl_bus_stage
   import ovl_pkg::*;
#(
   parameter int              AW       = 16,
   parameter int              DW       = 8,
   parameter logic [AW-1:0]   VEC_ADDR = 16'hFFEE
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] reset_addr,
   input  logic          acc_8bit,
   input  logic          irq,
   input  logic          int_dis,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] mem_addr,
   output logic          mem_rd,
   output logic [DW-1:0] mdr,
   output work_op_t      work_op
);
   bus_state_t    state_q, state_n;
   logic [AW-1:0] pc_q, pc_n;
   logic [DW-1:0] opc_q, opc_n;
   logic          take_q, take_n;
   logic          test_now;
   logic          take_now;
   work_op_t      work_n;

   assign take_now = irq & ~int_dis;

   always_comb begin
      state_n  = state_q;
      pc_n     = pc_q;
      opc_n    = opc_q;
      take_n   = take_q;
      work_n   = WK_IDLE;
      mem_addr = pc_q;
      mem_rd   = 1'b0;
      test_now = 1'b0;
      unique case (state_q)
         BS_FETCH: begin
            mem_rd = 1'b1;
            if (take_q) begin
               mem_addr = VEC_ADDR;
               work_n   = WK_VEC_LO;
               take_n   = 1'b0;
               state_n  = BS_VEC_HI;
            end else begin
               pc_n    = pc_q + AW'(1);
               opc_n   = mem_rdata;
               state_n = (mem_rdata == DW'(OPC_LOAD_IMM)) ? BS_OPND_LO : BS_IMPLIED;
            end
         end
         BS_OPND_LO: begin
            mem_rd = 1'b1;
            pc_n   = pc_q + AW'(1);
            work_n = WK_ACC_LO;
            if (acc_8bit) begin
               test_now = 1'b1;
               state_n  = BS_FETCH;
            end else begin
               state_n  = BS_OPND_HI;
            end
         end
         BS_OPND_HI: begin
            mem_rd   = 1'b1;
            pc_n     = pc_q + AW'(1);
            work_n   = WK_ACC_HI;
            test_now = 1'b1;
            state_n  = BS_FETCH;
         end
         BS_IMPLIED: begin
            test_now = 1'b1;
            mem_rd   = take_now;
            if (opc_q == DW'(OPC_DIS_CLR))      work_n = WK_FLAG_CLR;
            else if (opc_q == DW'(OPC_DIS_SET)) work_n = WK_FLAG_SET;
            else                                work_n = WK_IDLE;
            state_n  = BS_FETCH;
         end
         BS_VEC_HI: begin
            mem_rd   = 1'b1;
            mem_addr = VEC_ADDR + AW'(1);
            pc_n     = AW'({mem_rdata, mdr});
            work_n   = WK_VEC_HI;
            state_n  = BS_FETCH;
         end
         default: state_n = BS_FETCH;
      endcase
      if (test_now) take_n = take_now;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= BS_FETCH;
         pc_q    <= reset_addr;
         opc_q   <= '0;
         take_q  <= 1'b0;
         mdr     <= '0;
         work_op <= WK_IDLE;
      end else begin
         state_q <= state_n;
         pc_q    <= pc_n;
         opc_q   <= opc_n;
         take_q  <= take_n;
         work_op <= work_n;
         if (mem_rd) mdr <= mem_rdata;
      end
   end

   // R6
   irq_vector_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_now && irq && !int_dis) |=> (mem_rd && mem_addr == VEC_ADDR));

   // R7
   implied_pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BS_IMPLIED) |=> (pc_q == $past(pc_q)));

   // R5
   implied_read_only_before_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == BS_IMPLIED && mem_rd) |=> (mem_addr == VEC_ADDR));

   // R11
   masked_irq_no_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_now && int_dis) |=> (state_q == BS_FETCH && mem_addr != VEC_ADDR || pc_q == VEC_ADDR));
endmodule

// File: rtl/ovl_work_stage.sv
module ovl_work_stage
   import ovl_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  work_op_t        work_op,
   input  logic [DW-1:0]   mdr,
   output logic [2*DW-1:0] acc,
   output logic            int_dis,
   output logic            vec_valid,
   output logic [AW-1:0]   vector
);
   logic [DW-1:0] vec_lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc      <= '0;
         int_dis  <= 1'b1;
         vec_lo_q <= '0;
      end else begin
         unique case (work_op)
            WK_ACC_LO:   acc[DW-1:0]    <= mdr;
            WK_ACC_HI:   acc[2*DW-1:DW] <= mdr;
            WK_FLAG_CLR: int_dis        <= 1'b0;
            WK_FLAG_SET: int_dis        <= 1'b1;
            WK_VEC_LO: begin
               vec_lo_q <= mdr;
               int_dis  <= 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign vec_valid = (work_op == WK_VEC_HI);
   assign vector    = AW'({mdr, vec_lo_q});

   // R10
   vec_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> int_dis);

   // R10
   vec_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);

   // R4
   acc_lo_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (work_op == WK_ACC_LO) |=> (acc[DW-1:0] == $past(mdr)));
endmodule

// File: rtl/ovl_irq_seq.sv
module ovl_irq_seq
   import ovl_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            DW       = 8,
   parameter logic [AW-1:0] VEC_ADDR = 16'hFFEE
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   reset_addr,
   input  logic            acc_8bit,
   input  logic            irq,
   input  logic [DW-1:0]   mem_rdata,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_rd,
   output logic [2*DW-1:0] acc,
   output logic            int_dis,
   output logic            vec_valid,
   output logic [AW-1:0]   vector
);
   localparam int VEC_SPAN = 2 * DW;

   generate
      if (DW < 8) begin : g_dw_chk
         $error("DW must be at least 8 to hold an opcode");
      end
      if (AW < 2 || AW > VEC_SPAN) begin : g_aw_chk
         $error("AW must lie between 2 and twice DW");
      end
   endgenerate

   logic [DW-1:0] mdr;
   work_op_t      work_op;

   ovl_bus_stage #(.AW(AW), .DW(DW), .VEC_ADDR(VEC_ADDR)) bus_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .reset_addr (reset_addr),
      .acc_8bit   (acc_8bit),
      .irq        (irq),
      .int_dis    (int_dis),
      .mem_rdata  (mem_rdata),
      .mem_addr   (mem_addr),
      .mem_rd     (mem_rd),
      .mdr        (mdr),
      .work_op    (work_op)
   );

   ovl_work_stage #(.AW(AW), .DW(DW)) work_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .work_op   (work_op),
      .mdr       (mdr),
      .acc       (acc),
      .int_dis   (int_dis),
      .vec_valid (vec_valid),
      .vector    (vector)
   );

   // R10
   vec_after_two_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ($past(mem_rd) && $past(mem_addr) == VEC_ADDR + AW'(1)));

   // R10
   vec_fetch_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (mem_rd && mem_addr == vector));
endmodule

// File: tb/ovl_irq_seq_tb.sv
`timescale 1ns/1ps
module ovl_irq_seq_tb_top;
   localparam int            AW   = 16;
   localparam int            DW   = 8;
   localparam logic [AW-1:0] VADR = 16'hFFEE;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [AW-1:0]   reset_addr = 16'h0020;
   logic            acc_8bit = 1'b1;
   logic            irq = 1'b0;
   logic [DW-1:0]   mem_rdata;
   logic [AW-1:0]   mem_addr;
   logic            mem_rd;
   logic [2*DW-1:0] acc;
   logic            int_dis;
   logic            vec_valid;
   logic [AW-1:0]   vector;

   logic [7:0] mem [256];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:0]];

   ovl_irq_seq #(.AW(AW), .DW(DW), .VEC_ADDR(VADR)) dut_i (
      .clk(clk), .rst_n(rst_n), .reset_addr(reset_addr), .acc_8bit(acc_8bit),
      .irq(irq), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .acc(acc), .int_dis(int_dis), .vec_valid(vec_valid), .vector(vector)
   );

   // acc_8bit, low operand, high operand
   localparam logic [16:0] LOADS [6] = '{
      {1'b1, 8'h12, 8'h34},
      {1'b0, 8'h12, 8'h34},
      {1'b1, 8'hFF, 8'h00},
      {1'b0, 8'h00, 8'hFF},
      {1'b0, 8'h5A, 8'hC3},
      {1'b1, 8'h80, 8'h7E}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic fill_prog(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
      for (int i = 0; i < 256; i++) mem[i] = 8'hEA;
      mem[8'h20] = b0; mem[8'h21] = b1; mem[8'h22] = b2; mem[8'h23] = b3;
      mem[8'hEE] = 8'h40; mem[8'hEF] = 8'h00;
   endtask

   // leaves the bench at the negedge that shows bus cycle 0
   task automatic restart(input logic [AW-1:0] ra);
      @(negedge clk);
      rst_n = 1'b0;
      reset_addr = ra;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      fill_prog(8'hEA, 8'hEA, 8'hEA, 8'hEA);
      // R1 reset state at a distinct start address
      restart(16'h0055);
      check("R1 acc", acc, 0);
      check("R1 int_dis", int_dis, 1);
      check("R1 vec_valid", vec_valid, 0);
      check("R1 first read", mem_rd, 1);
      check("R1 first addr", mem_addr, 32'h0055);

      // R2 R3 R4 table walk, irq low
      for (int i = 0; i < 6; i++) begin
         logic        w8;
         logic [7:0]  lo, hi;
         {w8, lo, hi} = LOADS[i];
         fill_prog(8'hA9, lo, hi, 8'hEA);
         acc_8bit = w8;
         restart(16'h0020);
         step(2);                       // cycle 2
         check("R4 acc not yet", acc, 0);
         step(1);                       // cycle 3
         check("R4 acc low lag", acc, {8'h00, lo});
         check("R2 R3 cycle3 read", mem_rd, !w8);
         step(1);                       // cycle 4
         check(w8 ? "R2 acc 8bit" : "R3 acc 16bit", acc, w8 ? {8'h00, lo} : {hi, lo});
      end

      // R5 R11 masked irq: implied cycles stay idle
      acc_8bit = 1'b1;
      fill_prog(8'hEA, 8'hEA, 8'hEA, 8'hEA);
      irq = 1'b1;
      restart(16'h0020);
      step(1);
      check("R5 idle cycle", mem_rd, 0);
      step(1);
      check("R11 next opcode", mem_addr, 32'h0021);
      step(1);
      check("R11 still idle", mem_rd, 0);
      step(1);
      check("R11 no vector", mem_addr, 32'h0022);

      // R8 R7 R10 clear flag then implied, irq held
      fill_prog(8'h58, 8'hEA, 8'hEA, 8'hEA);
      restart(16'h0020);
      step(1);
      check("R8 not taken in clear op", mem_rd, 0);
      step(1);
      check("R8 next opcode read", mem_addr, 32'h0021);
      check("R8 flag still set", int_dis, 1);
      step(1);
      check("R7 idle turned read", mem_rd, 1);
      check("R7 read addr", mem_addr, 32'h0022);
      check("R8 flag cleared", int_dis, 0);
      step(1);
      check("R6 vector lo addr", mem_addr, VADR);
      step(1);
      check("R10 vector hi addr", mem_addr, VADR + 16'h1);
      check("R10 no early strobe", vec_valid, 0);
      step(1);
      check("R10 strobe", vec_valid, 1);
      check("R10 vector", vector, 32'h0040);
      check("R10 fetch at vector", mem_addr, 32'h0040);
      check("R10 flag set", int_dis, 1);
      step(1);
      check("R10 strobe one cycle", vec_valid, 0);

      // R9 set flag cannot block its own test
      fill_prog(8'h58, 8'h78, 8'hEA, 8'hEA);
      restart(16'h0020);
      step(3);
      check("R9 converted read", mem_rd, 1);
      check("R9 converted addr", mem_addr, 32'h0022);
      step(1);
      check("R9 vector fetch", mem_addr, VADR);

      // R6 R3 test in high-byte fetch, load completes
      acc_8bit = 1'b0;
      fill_prog(8'h58, 8'hA9, 8'h11, 8'h22);
      restart(16'h0020);
      step(4);
      check("R6 hi byte read", mem_addr, 32'h0023);
      step(1);
      check("R6 vector after 16bit load", mem_addr, VADR);
      step(2);
      check("R3 acc after irq", acc, 32'h2211);
      check("R10 strobe after load", vec_valid, 1);

      // R6 R2 test in low-byte fetch for 8-bit
      acc_8bit = 1'b1;
      fill_prog(8'h58, 8'hA9, 8'h33, 8'hEA);
      restart(16'h0020);
      step(3);
      check("R6 lo byte read", mem_addr, 32'h0022);
      step(1);
      check("R6 vector after 8bit load", mem_addr, VADR);
      step(1);
      check("R2 acc after irq", acc, 32'h0033);

      irq = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule